// File: doc/BRIEF.md
# Signed extended word divider

This unit sits in a processor execute stage. It performs a signed divide in which the dividend is widened before the divide. The low word of operand A becomes the upper half of a double-width signed dividend, and the lower half is zero. The divisor is the low word of operand B, sign-extended to double width. The quotient is returned as a signed word, sign-extended to the register width. When the quotient cannot be held in a signed word, or the divisor is zero, the result is forced to zero and an overflow is reported.

A one-cycle `start` launches an operation. The controller has three states. ST_IDLE waits for `start`. On a nonzero divisor it takes the transition "launch" to ST_ITER. On a zero divisor it takes "fast finish" and stays in ST_IDLE, completing at once. ST_ITER runs 64 restoring shift-subtract steps on operand magnitudes. After the last step it takes "last step" to ST_WRAP. ST_WRAP applies the sign, runs the word-fit check, writes the result and flags, pulses `done`, and takes "retire" back to ST_IDLE. The unit holds two flags: a sticky summary flag and a live overflow flag. Both change only when an operation completes with `ovf_en` set.

Top module: `ewd_top`

## Requirements
- R1: The quotient is (A[31:0] * 2^32) divided by sign-extended B[31:0], truncated toward zero. Bits 63:32 of both operands are ignored. `result` is the 32-bit quotient sign-extended to 64 bits.
- R2: A quotient outside the range -2^31 to 2^31-1 is an overflow and gives `result` = 0. The value -2^31 itself fits.
- R3: B[31:0] = 0 is an overflow with `result` = 0. `done` is high in the cycle after the single clock edge that samples `start`.
- R4: A[31:0] = 0x80000000 with B[31:0] = 0xFFFFFFFF is an overflow with `result` = 0.
- R5: With `ovf_en` = 1 and an overflow, both `ov_flag` and `so_flag` become 1.
- R6: With `ovf_en` = 1 and no overflow, `ov_flag` becomes 0 and `so_flag` keeps its value. `so_flag` never falls except at reset.
- R7: With `ovf_en` = 0, neither flag changes.
- R8: For a nonzero divisor, `done` is high in the cycle after the 66th rising edge, counting the edge that samples `start` as the first. `done` is high for exactly one cycle.
- R9: `start` is ignored while `busy` is high. The running operation keeps its operands and its latency.
- R10: Reset clears `result`, `done`, `busy`, `so_flag` and `ov_flag`. `result` and both flags change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| opa | input | 64 | Operand A; the low word forms the dividend |
| opb | input | 64 | Operand B; the low word is the divisor |
| ovf_en | input | 1 | Allows the flags to be updated |
| result | output | 64 | Sign-extended word quotient, or zero on overflow |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An operation is in progress |
| so_flag | output | 1 | Sticky summary overflow |
| ov_flag | output | 1 | Overflow of the latest enabled operation |

## Verification
The bench aims at the edges of the word-fit check. A quotient of exactly +2^31 must overflow, while -2^31 must pass. A fit check that ignored the sign would get one of these two wrong. It also tests the most-negative dividend divided by -1. A magnitude datapath that is one bit too narrow would wrap on this case and return a small bogus quotient. A zero divisor must finish after one edge. A design that iterated instead would show a latency of 66, and one that skipped the check would return all ones. The bench also runs ops with the flag enable cleared, to catch flags that leak on every operation. It issues a stray `start` during a busy divide, so a controller that restarts would show a longer latency and a different quotient.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_WRAP = 2'd2
    } ewd_state_e;
endpackage

// File: rtl/ewd_fsm.sv
module ewd_fsm
    import ewd_pkg::*;
#(
    parameter int ITERS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic div_zero,
    output logic load,
    output logic fast,
    output logic step,
    output logic wrap,
    output logic busy
);
    localparam int CW = $clog2(ITERS);
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    ewd_state_e state, state_nx;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_ITER) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        load = 1'b0;
        fast = 1'b0;
        step = 1'b0;
        wrap = 1'b0;
        busy = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    if (div_zero) fast = 1'b1;      // fast finish
                    else begin
                        load     = 1'b1;            // launch
                        state_nx = ST_ITER;
                    end
                end
            end
            ST_ITER: begin
                step = 1'b1;
                if (cnt == LAST) state_nx = ST_WRAP; // last step
            end
            ST_WRAP: begin
                wrap     = 1'b1;
                state_nx = ST_IDLE;                 // retire
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R3: zero divisor never leaves idle
    a_r3_fast_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fast |=> state == ST_IDLE);
    // R8: leave iteration exactly after the final step
    a_r8_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER && cnt == LAST) |=> state == ST_WRAP);
    // R9: a running divide advances regardless of start
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER && cnt != LAST) |=> (state == ST_ITER && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ewd_core.sv
module ewd_core #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] dvd_mag,
    input  logic [DW-1:0] dvs_mag,
    output logic [DW-1:0] quo
);
    logic [DW:0]   rem;
    logic [DW-1:0] dvs;
    logic [DW:0]   rem_sh;
    logic [DW+1:0] diff;

    always_comb begin
        rem_sh = {rem[DW-1:0], quo[DW-1]};
        diff   = {1'b0, rem_sh} - {2'b00, dvs};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            quo <= '0;
            dvs <= '0;
        end else if (load) begin
            rem <= '0;
            quo <= dvd_mag;
            dvs <= dvs_mag;
        end else if (step) begin
            if (diff[DW+1]) begin
                rem <= rem_sh;
                quo <= {quo[DW-2:0], 1'b0};
            end else begin
                rem <= diff[DW:0];
                quo <= {quo[DW-2:0], 1'b1};
            end
        end
    end

    // R1: partial remainder always stays below the divisor during iteration
    a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step) |-> rem < {1'b0, dvs});
endmodule

// File: rtl/ewd_pack.sv
module ewd_pack #(
    parameter int DW   = 64,
    parameter int WORD = 32,
    parameter int XLEN = 64
) (
    input  logic [DW-1:0]   mag,
    input  logic            neg,
    output logic [XLEN-1:0] res,
    output logic            no_fit
);
    localparam logic [DW-1:0] LIM = DW'(1) << (WORD - 1);
    logic [WORD-1:0] q_word;

    always_comb begin
        no_fit = neg ? (mag > LIM) : (mag >= LIM);
        q_word = neg ? (~mag[WORD-1:0] + 1'b1) : mag[WORD-1:0];
    end

    generate
        if (XLEN > WORD) begin : g_ext
            assign res = {{(XLEN-WORD){q_word[WORD-1]}}, q_word};
        end else begin : g_flat
            assign res = q_word;
        end
    endgenerate
endmodule

// File: rtl/ewd_top.sv
module ewd_top #(
    parameter int XLEN = 64,
    parameter int WORD = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            ovf_en,
    output logic [XLEN-1:0] result,
    output logic            done,
    output logic            busy,
    output logic            so_flag,
    output logic            ov_flag
);
    localparam int DW = 2 * WORD;

    logic [WORD-1:0] a_w, b_w;
    logic [DW-1:0]   dvd_s, dvs_s, dvd_mag, dvs_mag, quo;
    logic            div_zero, load, fast, step, wrap;
    logic            neg_q, oe_q, no_fit;
    logic [XLEN-1:0] packed_res;

    always_comb begin
        a_w      = opa[WORD-1:0];
        b_w      = opb[WORD-1:0];
        dvd_s    = {a_w, {WORD{1'b0}}};
        dvs_s    = {{WORD{b_w[WORD-1]}}, b_w};
        dvd_mag  = a_w[WORD-1] ? (~dvd_s + 1'b1) : dvd_s;
        dvs_mag  = b_w[WORD-1] ? (~dvs_s + 1'b1) : dvs_s;
        div_zero = (b_w == '0);
    end

    ewd_fsm #(.ITERS(DW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .div_zero(div_zero),
        .load(load), .fast(fast), .step(step), .wrap(wrap), .busy(busy)
    );

    ewd_core #(.DW(DW)) core_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .quo(quo)
    );

    ewd_pack #(.DW(DW), .WORD(WORD), .XLEN(XLEN)) pack_i (
        .mag(quo), .neg(neg_q), .res(packed_res), .no_fit(no_fit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            done    <= 1'b0;
            so_flag <= 1'b0;
            ov_flag <= 1'b0;
            neg_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                neg_q <= a_w[WORD-1] ^ b_w[WORD-1];
                oe_q  <= ovf_en;
            end
            if (fast) begin
                result <= '0;
                done   <= 1'b1;
                if (ovf_en) begin
                    so_flag <= 1'b1;
                    ov_flag <= 1'b1;
                end
            end else if (wrap) begin
                result <= no_fit ? '0 : packed_res;
                done   <= 1'b1;
                if (oe_q) begin
                    ov_flag <= no_fit;
                    if (no_fit) so_flag <= 1'b1;
                end
            end
        end
    end

    // R2: an enabled overflow always comes with a zero result
    a_r2_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_flag) |-> result == '0);
    // R6: summary flag is sticky
    a_r6_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(so_flag));
    // R8: done lasts one cycle unless a zero-divisor start follows at once
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(start && div_zero)) |=> !done);
    // R10: outputs move only with done
    a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(so_flag) && $stable(ov_flag)));

    generate
        if (XLEN > WORD) begin : g_sx_chk
            // R1: upper half mirrors the word sign
            a_r1_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> result[XLEN-1:WORD] == {(XLEN-WORD){result[WORD-1]}});
        end
    endgenerate
endmodule

// File: tb/ewd_top_tb_top.sv
module ewd_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        ovf_en = 1'b0;
    logic [63:0] result;
    logic        done, busy, so_flag, ov_flag;

    int checks = 0;
    int errors = 0;
    logic so_m = 1'b0, ov_m = 1'b0;

    always #2 clk = ~clk;

    ewd_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .ovf_en(ovf_en), .result(result), .done(done), .busy(busy),
        .so_flag(so_flag), .ov_flag(ov_flag)
    );

    // {oe, a_word, b_word}
    localparam int NV = 10;
    localparam logic [64:0] VEC [0:NV-1] = '{
        {1'b1, 32'h00000001, 32'h00000002},
        {1'b1, 32'h00000001, 32'h00000003},
        {1'b1, 32'hFFFFFFFF, 32'h00000007},
        {1'b0, 32'h00000005, 32'hFFFFFFF0},
        {1'b1, 32'h00000000, 32'h00001234},
        {1'b1, 32'h80000000, 32'hFFFFFFFF},
        {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {1'b1, 32'h00000001, 32'hFFFFFFFE},
        {1'b1, 32'h00000003, 32'h7FFFFFFF},
        {1'b1, 32'h12345678, 32'h7FFFFFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         output logic ovf, output logic [63:0] res);
        longint dvd, dvs, q;
        dvd = longint'({a, 32'h0});
        dvs = longint'($signed(b));
        res = '0;
        if (dvs == 0) ovf = 1'b1;
        else if (dvd == 64'sh8000000000000000 && dvs == -1) ovf = 1'b1;
        else begin
            q   = dvd / dvs;
            ovf = (q != longint'(int'(q)));
            if (!ovf) res = 64'(q);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic oe,
                          input bit poke, output int lat);
        @(negedge clk);
        opa = {32'hDEADBEEF, a};
        opb = {32'hC0FFEE00, b};
        ovf_en = oe;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 300) begin
            if (poke && lat == 10) begin
                start = 1'b1;
                opa = 64'h0000000700000007;
                opb = 64'h0000000000000001;
                ovf_en = ~oe;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
    endtask

    task automatic check_op(input logic [31:0] a, input logic [31:0] b, input logic oe,
                            input string tag, input int exp_lat, input bit poke);
        logic ovf;
        logic [63:0] exp_res;
        int lat;
        model(a, b, ovf, exp_res);
        if (oe) begin
            if (ovf) begin so_m = 1'b1; ov_m = 1'b1; end
            else ov_m = 1'b0;
        end
        run_op(a, b, oe, poke, lat);
        chk({tag, " result"}, result, exp_res);
        chk("R5/R6/R7 ov_flag", 64'(ov_flag), 64'(ov_m));
        chk("R5/R6/R7 so_flag", 64'(so_flag), 64'(so_m));
        chk("R8 latency", 64'(lat), 64'(exp_lat));
        @(negedge clk);
        chk("R8 done pulse", 64'(done), 64'd0);
        chk("R10 result held", result, exp_res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset result", result, 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset so", 64'(so_flag), 64'd0);
        chk("R10 reset ov", 64'(ov_flag), 64'd0);

        // R1 R2 R4 R5 R6 R7 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] a, b;
            logic ovf;
            logic [63:0] tmp;
            a = VEC[i][63:32];
            b = VEC[i][31:0];
            model(a, b, ovf, tmp);
            check_op(a, b, VEC[i][64], ovf ? "R2/R4" : "R1", 66, 1'b0);
        end

        // R7: clear ov with a clean op, then overflow with enable low
        check_op(32'h00000001, 32'h00000003, 1'b1, "R1", 66, 1'b0);
        check_op(32'h00000001, 32'h00000002, 1'b0, "R7", 66, 1'b0);
        // R3: zero divisor, both enable settings
        check_op(32'h00000002, 32'h00000000, 1'b0, "R3", 1, 1'b0);
        check_op(32'h00000002, 32'h00000000, 1'b1, "R3", 1, 1'b0);
        // R9: stray start while busy
        check_op(32'hFFFFFFFF, 32'h00000007, 1'b1, "R9", 66, 1'b1);
        // R10: outputs hold while idle
        repeat (5) @(negedge clk);
        chk("R10 idle hold result", result, 64'hFFFFFFFFDB6DB6DC);
        chk("R10 idle hold ov", 64'(ov_flag), 64'(ov_m));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule